// File: doc/BRIEF.md
# Process-Tagged Translation Lookaside Buffer

This block is a small, fully associative address translation buffer. Its entries are filled and inspected by software through four assist registers. A lookup returns its result combinationally, in the same cycle as the request. The lookup carries an effective address, the current process ID, the instruction-space and data-space bits, and a flag that says whether it is an instruction fetch or a data access. The block answers with a hit flag, the index of the matching entry, the translated real address and a multi-hit flag.

Software fills an entry in two steps. It first writes the staging fields of the assist registers. It then pulses a write command, which copies them into the entry named by the entry-select field. A read command does the reverse and copies the selected entry back into the staging fields. An entry can be marked protected. A protected entry survives both invalidate-by-address and flash invalidation. On a lookup miss, the next-victim index kept by software is copied into the entry-select field, so the refill routine can write straight away.

Top module: `tlb_core`

## Requirements
- R1: After reset no entry is valid, so every lookup misses and a read-back of any entry shows VALID (CONTEXT bit 31) as 0. The SELECT register reads 0.
- R2: An entry whose VALID bit is 0 never produces a hit.
- R3: An entry with translation ID 0 matches any process ID. An entry with a nonzero ID matches only when the ID equals `cur_pid`.
- R4: The entry's space bit must equal `msr_is` for a fetch (`lk_is_data`=0) and `msr_ds` for a data access (`lk_is_data`=1).
- R5: Size code s covers 4 KB·4^s. The low 2·s bits of the page number are ignored in the compare. Those bits pass from the effective address into the real address, and the 12 offset bits always pass through.
- R6: The lookup result appears in the same cycle as `lk_valid`. When several entries match, `lk_multi` is 1 and the lowest-index match supplies `lk_idx` and `lk_ra`. Without `lk_valid`, `lk_hit` is 0.
- R7: The assist registers are selected by `reg_sel`: 0=SELECT, 1=CONTEXT, 2=EPN, 3=RPN. `cmd_write` stores the staging fields into the entry named by entry-select, and `cmd_read` loads that entry into the staging fields. CONTEXT holds VALID at bit 31, protect at bit 30, ID at bits 23:16, space at bit 8 and size at bits 3:0. EPN and RPN hold the page number at bits 31:12.
- R8: SELECT holds entry-select at bits 4:0 and next-victim at bits 12:8. A lookup miss copies next-victim into entry-select in the following cycle. A software write of SELECT in that same cycle wins.
- R9: `cmd_inval` clears every unprotected entry whose page covers `inv_pn`, whatever its ID or space. Protected entries keep working.
- R10: `cmd_flash` clears every unprotected entry in one cycle and leaves protected ones. An entry written in the same cycle takes the written value.
- R11: Bits of the assist registers that hold no field read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_is_data | input | 1 | 1 = data access, 0 = instruction fetch |
| lk_ea | input | 32 | Effective address |
| cur_pid | input | 8 | Current process ID |
| msr_is | input | 1 | Instruction address-space bit |
| msr_ds | input | 1 | Data address-space bit |
| lk_hit | output | 1 | Lookup hit |
| lk_idx | output | 5 | Index of the hitting entry |
| lk_ra | output | 32 | Translated real address |
| lk_multi | output | 1 | More than one entry matched |
| reg_wr | input | 1 | Assist register write strobe |
| reg_sel | input | 2 | Assist register select |
| reg_wdata | input | 32 | Assist register write data |
| reg_rdata | output | 32 | Assist register read data |
| cmd_write | input | 1 | Store staging fields into selected entry |
| cmd_read | input | 1 | Load selected entry into staging fields |
| cmd_inval | input | 1 | Invalidate by page number |
| inv_pn | input | 20 | Page number for invalidate |
| cmd_flash | input | 1 | Flash invalidate |

## Verification
The checker watches several rules on every cycle. A multi-hit never appears without a hit, and the reported index is always the lowest-index matching entry. A miss places the next-victim index in entry-select on the following cycle. A flash leaves no unprotected entry valid, and reserved register bits never read as 1. Only the bench scenarios can show that the translation itself is right: the global-ID and space rules, the size-dependent masking of the address, the readback of entries, invalidate-by-address sparing protected pages, and a write that lands in the same cycle as a flash.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W  = 32;
    localparam int OFF_W = 12;
    localparam int PN_W  = VA_W - OFF_W;
    localparam int TID_W = 8;
    localparam int SZ_W  = 4;
    localparam int SEL_W = 5;

    localparam logic [31:0] SELECT_RMASK  = 32'h0000_1F1F;
    localparam logic [31:0] CONTEXT_RMASK = 32'hC0FF_010F;
    localparam logic [31:0] PAGE_RMASK    = 32'hFFFF_F000;

    typedef enum logic [1:0] {
        AREG_SELECT  = 2'd0,
        AREG_CONTEXT = 2'd1,
        AREG_EPN     = 2'd2,
        AREG_RPN     = 2'd3
    } areg_e;

    typedef struct packed {
        logic             valid;
        logic             iprot;
        logic [TID_W-1:0] tid;
        logic             ts;
        logic [SZ_W-1:0]  size;
        logic [PN_W-1:0]  epn;
        logic [PN_W-1:0]  rpn;
    } tlb_entry_t;

    // fields the comparators need
    typedef struct packed {
        logic             valid;
        logic [TID_W-1:0] tid;
        logic             ts;
        logic [SZ_W-1:0]  size;
        logic [PN_W-1:0]  epn;
    } tlb_key_t;

    // page-number bits that fall inside the page for a size code
    function automatic logic [PN_W-1:0] size_mask(input logic [SZ_W-1:0] code);
        logic [PN_W-1:0] m;
        for (int b = 0; b < PN_W; b++) begin
            m[b] = (b < 2 * int'(code));
        end
        return m;
    endfunction

    function automatic tlb_key_t to_key(input tlb_entry_t e);
        tlb_key_t k;
        k.valid = e.valid;
        k.tid   = e.tid;
        k.ts    = e.ts;
        k.size  = e.size;
        k.epn   = e.epn;
        return k;
    endfunction

    function automatic logic [31:0] ctx_pack(input tlb_entry_t e);
        logic [31:0] r;
        r        = '0;
        r[31]    = e.valid;
        r[30]    = e.iprot;
        r[23:16] = e.tid;
        r[8]     = e.ts;
        r[3:0]   = e.size;
        return r;
    endfunction

    function automatic logic [31:0] sel_pack(input logic [SEL_W-1:0] esel,
                                             input logic [SEL_W-1:0] nv);
        logic [31:0] r;
        r       = '0;
        r[4:0]  = esel;
        r[12:8] = nv;
        return r;
    endfunction

    function automatic logic [PN_W-1:0] xlate_pn(input tlb_entry_t e,
                                                 input logic [PN_W-1:0] ea_pn);
        logic [PN_W-1:0] m;
        m = size_mask(e.size);
        return (e.rpn & ~m) | (ea_pn & m);
    endfunction
endpackage

// File: rtl/tlb_assist_regs.sv
module tlb_assist_regs
    import tlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [1:0]       reg_sel,
    input  logic [31:0]      reg_wdata,
    input  logic             load_en,
    input  tlb_entry_t       load_entry,
    input  logic             miss_load,
    output logic [SEL_W-1:0] esel,
    output logic [SEL_W-1:0] nv,
    output tlb_entry_t       stage,
    output logic [31:0]      rdata
);
    areg_e            sel;
    logic             wr_sel, wr_ctx, wr_epn, wr_rpn;
    logic [SEL_W-1:0] esel_q, nv_q;
    tlb_entry_t       stage_q;
    logic             unused_wbits;

    assign sel    = areg_e'(reg_sel);
    assign wr_sel = reg_wr && (sel == AREG_SELECT);
    assign wr_ctx = reg_wr && (sel == AREG_CONTEXT);
    assign wr_epn = reg_wr && (sel == AREG_EPN);
    assign wr_rpn = reg_wr && (sel == AREG_RPN);
    assign unused_wbits = ^reg_wdata;

    // software write of SELECT beats the miss load
    always_ff @(posedge clk) begin
        if (rst) begin
            esel_q <= '0;
            nv_q   <= '0;
        end else if (wr_sel) begin
            esel_q <= reg_wdata[4:0];
            nv_q   <= reg_wdata[12:8];
        end else if (miss_load) begin
            esel_q <= nv_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else if (load_en) begin
            stage_q <= load_entry;
        end else begin
            if (wr_ctx) begin
                stage_q.valid <= reg_wdata[31];
                stage_q.iprot <= reg_wdata[30];
                stage_q.tid   <= reg_wdata[23:16];
                stage_q.ts    <= reg_wdata[8];
                stage_q.size  <= reg_wdata[3:0];
            end
            if (wr_epn) stage_q.epn <= reg_wdata[31:OFF_W];
            if (wr_rpn) stage_q.rpn <= reg_wdata[31:OFF_W];
        end
    end

    always_comb begin
        unique case (sel)
            AREG_SELECT:  rdata = sel_pack(esel_q, nv_q);
            AREG_CONTEXT: rdata = ctx_pack(stage_q);
            AREG_EPN:     rdata = {stage_q.epn, {OFF_W{1'b0}}};
            AREG_RPN:     rdata = {stage_q.rpn, {OFF_W{1'b0}}};
            default:      rdata = '0;
        endcase
    end

    assign esel  = esel_q;
    assign nv    = nv_q;
    assign stage = stage_q;
endmodule

// File: rtl/tlb_entry_array.sv
module tlb_entry_array
    import tlb_pkg::*;
#(
    parameter int N = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_idx,
    input  tlb_entry_t       wr_entry,
    input  logic             inv_en,
    input  logic [PN_W-1:0]  inv_pn,
    input  logic             flash_en,
    output tlb_entry_t       entries [N]
);
    for (genvar i = 0; i < N; i++) begin : g_ent
        logic       v_q;
        tlb_entry_t b_q;
        logic       wr_me, inv_me, drop;

        assign wr_me  = wr_en && (wr_idx == SEL_W'(i));
        assign inv_me = inv_en &&
                        (((b_q.epn ^ inv_pn) & ~size_mask(b_q.size)) == '0);
        assign drop   = (flash_en || inv_me) && !b_q.iprot;

        // only VALID is reset; a write beats any invalidate
        always_ff @(posedge clk) begin
            if (rst)        v_q <= 1'b0;
            else if (wr_me) v_q <= wr_entry.valid;
            else if (drop)  v_q <= 1'b0;
        end

        always_ff @(posedge clk) begin
            if (wr_me) b_q <= wr_entry;
        end

        always_comb begin
            entries[i]       = b_q;
            entries[i].valid = v_q;
        end
    end
endmodule

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
#(
    parameter int N = 32
) (
    input  tlb_key_t         keys [N],
    input  logic [PN_W-1:0]  ea_pn,
    input  logic [TID_W-1:0] pid,
    input  logic             as_bit,
    output logic [N-1:0]     match_vec
);
    for (genvar i = 0; i < N; i++) begin : g_cmp
        logic id_ok, as_ok, pn_ok;
        assign id_ok = (keys[i].tid == '0) || (keys[i].tid == pid);
        assign as_ok = (keys[i].ts == as_bit);
        assign pn_ok = ((keys[i].epn ^ ea_pn) & ~size_mask(keys[i].size)) == '0;
        assign match_vec[i] = keys[i].valid && id_ok && as_ok && pn_ok;
    end
endmodule

// File: rtl/tlb_prio_enc.sv
module tlb_prio_enc
    import tlb_pkg::*;
#(
    parameter int N = 32
) (
    input  logic [N-1:0]     vec,
    output logic             any,
    output logic             multi,
    output logic [SEL_W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = SEL_W'(i);
        end
    end

    assign any   = |vec;
    assign multi = (vec & (vec - N'(1))) != '0;
endmodule

// File: rtl/tlb_core.sv
module tlb_core
    import tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        lk_valid,
    input  logic        lk_is_data,
    input  logic [31:0] lk_ea,
    input  logic [7:0]  cur_pid,
    input  logic        msr_is,
    input  logic        msr_ds,
    output logic        lk_hit,
    output logic [4:0]  lk_idx,
    output logic [31:0] lk_ra,
    output logic        lk_multi,
    input  logic        reg_wr,
    input  logic [1:0]  reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        cmd_write,
    input  logic        cmd_read,
    input  logic        cmd_inval,
    input  logic [19:0] inv_pn,
    input  logic        cmd_flash
);
    localparam int N = NUM_ENTRIES;

    tlb_entry_t       entries [N];
    tlb_key_t         keys    [N];
    tlb_entry_t       stage, rd_entry, hit_entry;
    logic [SEL_W-1:0] esel, nv, enc_idx;
    logic [N-1:0]     match_vec, valid_vec, iprot_vec;
    logic             enc_any, enc_multi, miss_load;
    logic [PN_W-1:0]  ea_pn;

    assign ea_pn     = lk_ea[VA_W-1:OFF_W];
    assign miss_load = lk_valid && !enc_any;

    for (genvar i = 0; i < N; i++) begin : g_vec
        assign keys[i]      = to_key(entries[i]);
        assign valid_vec[i] = entries[i].valid;
        assign iprot_vec[i] = entries[i].iprot;
    end

    tlb_assist_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .reg_wr     (reg_wr),
        .reg_sel    (reg_sel),
        .reg_wdata  (reg_wdata),
        .load_en    (cmd_read),
        .load_entry (rd_entry),
        .miss_load  (miss_load),
        .esel       (esel),
        .nv         (nv),
        .stage      (stage),
        .rdata      (reg_rdata)
    );

    tlb_entry_array #(.N(N)) u_array (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cmd_write),
        .wr_idx   (esel),
        .wr_entry (stage),
        .inv_en   (cmd_inval),
        .inv_pn   (inv_pn),
        .flash_en (cmd_flash),
        .entries  (entries)
    );

    tlb_match #(.N(N)) u_match (
        .keys      (keys),
        .ea_pn     (ea_pn),
        .pid       (cur_pid),
        .as_bit    (lk_is_data ? msr_ds : msr_is),
        .match_vec (match_vec)
    );

    tlb_prio_enc #(.N(N)) u_enc (
        .vec   (match_vec),
        .any   (enc_any),
        .multi (enc_multi),
        .idx   (enc_idx)
    );

    // entry muxes; an out-of-range select reads as zero
    always_comb begin
        rd_entry  = '0;
        hit_entry = '0;
        for (int i = 0; i < N; i++) begin
            if (esel == SEL_W'(i))    rd_entry  = entries[i];
            if (enc_idx == SEL_W'(i)) hit_entry = entries[i];
        end
    end

    always_comb begin
        lk_hit   = lk_valid && enc_any;
        lk_multi = lk_hit && enc_multi;
        lk_idx   = lk_hit ? enc_idx : '0;
        lk_ra    = lk_hit ? {xlate_pn(hit_entry, ea_pn), lk_ea[OFF_W-1:0]} : '0;
    end
endmodule

// File: rtl/tlb_checker.sv
module tlb_checker #(
    parameter int N = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         lk_valid,
    input logic         lk_hit,
    input logic         lk_multi,
    input logic [4:0]   lk_idx,
    input logic [N-1:0] match_vec,
    input logic [N-1:0] valid_vec,
    input logic [N-1:0] iprot_vec,
    input logic         cmd_flash,
    input logic         cmd_write,
    input logic [4:0]   esel,
    input logic [4:0]   nv,
    input logic         reg_wr,
    input logic [1:0]   reg_sel,
    input logic [31:0]  reg_rdata
);
    logic [N-1:0] below_idx;
    assign below_idx = (N'(1) << lk_idx) - N'(1);

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> valid_vec == '0);

    assert_idle_no_hit_R6: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |-> !lk_hit);

    assert_multi_needs_hit_R6: assert property (@(posedge clk) disable iff (rst)
        lk_multi |-> lk_hit);

    assert_lowest_index_R6: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> (match_vec[lk_idx] && ((match_vec & below_idx) == '0)));

    assert_miss_loads_victim_R8: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && !lk_hit && !(reg_wr && reg_sel == 2'd0)) |=> esel == $past(nv));

    assert_flash_clears_R10: assert property (@(posedge clk) disable iff (rst)
        (cmd_flash && !cmd_write) |=> (valid_vec & ~$past(iprot_vec)) == '0);

    assert_select_reserved_R11: assert property (@(posedge clk) disable iff (rst)
        (reg_sel == 2'd0) |-> (reg_rdata & ~32'h0000_1F1F) == '0);

    assert_context_reserved_R11: assert property (@(posedge clk) disable iff (rst)
        (reg_sel == 2'd1) |-> (reg_rdata & ~32'hC0FF_010F) == '0);
endmodule

bind tlb_core tlb_checker #(.N(NUM_ENTRIES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .lk_valid  (lk_valid),
    .lk_hit    (lk_hit),
    .lk_multi  (lk_multi),
    .lk_idx    (lk_idx),
    .match_vec (match_vec),
    .valid_vec (valid_vec),
    .iprot_vec (iprot_vec),
    .cmd_flash (cmd_flash),
    .cmd_write (cmd_write),
    .esel      (esel),
    .nv        (nv),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_rdata (reg_rdata)
);

// File: tb/sim_tlb_core.sv
`timescale 1ns/1ps
module sim_tlb_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid = 1'b0, lk_is_data = 1'b0, msr_is = 1'b0, msr_ds = 1'b0;
    logic [31:0] lk_ea = '0;
    logic [7:0]  cur_pid = '0;
    logic        lk_hit, lk_multi;
    logic [4:0]  lk_idx;
    logic [31:0] lk_ra, reg_rdata;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic        cmd_write = 1'b0, cmd_read = 1'b0, cmd_inval = 1'b0, cmd_flash = 1'b0;
    logic [19:0] inv_pn = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [4:0] nv_b = 5'd9;

    typedef struct {
        string       tag;
        logic        hit;
        logic [4:0]  idx;
        logic [31:0] ra;
        logic        multi;
    } exp_t;
    exp_t sb_q[$];

    always #4 clk = ~clk;   // 125 MHz

    tlb_core u0 (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_is_data(lk_is_data),
        .lk_ea(lk_ea), .cur_pid(cur_pid), .msr_is(msr_is), .msr_ds(msr_ds),
        .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_ra(lk_ra), .lk_multi(lk_multi),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .cmd_write(cmd_write), .cmd_read(cmd_read),
        .cmd_inval(cmd_inval), .inv_pn(inv_pn), .cmd_flash(cmd_flash)
    );

    // monitor: pops one expected item per lookup cycle
    always @(negedge clk) begin
        if (!rst && lk_valid) begin
            exp_t e;
            checks++;
            if (sb_q.size() == 0) begin
                fails++;
                $display("FAIL scoreboard empty: unexpected lookup, actual hit=%0b expected none", lk_hit);
            end else begin
                e = sb_q.pop_front();
                if (lk_hit !== e.hit ||
                    (e.hit && (lk_idx !== e.idx || lk_ra !== e.ra || lk_multi !== e.multi))) begin
                    fails++;
                    $display("FAIL %s: actual hit=%0b idx=%0d ra=%h multi=%0b expected hit=%0b idx=%0d ra=%h multi=%0b",
                             e.tag, lk_hit, lk_idx, lk_ra, lk_multi, e.hit, e.idx, e.ra, e.multi);
                end
            end
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic lookup(input string tag, input logic data, input logic [31:0] ea,
                          input logic [7:0] pid, input logic is_b, input logic ds_b,
                          input logic hit, input logic [4:0] idx, input logic [31:0] ra,
                          input logic multi);
        exp_t e;
        e.tag = tag; e.hit = hit; e.idx = idx; e.ra = ra; e.multi = multi;
        sb_q.push_back(e);
        lk_valid = 1'b1; lk_is_data = data; lk_ea = ea; cur_pid = pid;
        msr_is = is_b; msr_ds = ds_b;
        step();
        lk_valid = 1'b0;
    endtask

    task automatic reg_write(input logic [1:0] sel, input logic [31:0] d);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        step();
        reg_wr = 1'b0;
    endtask

    task automatic reg_check(input string tag, input logic [1:0] sel,
                             input logic [31:0] mask, input logic [31:0] exp);
        reg_sel = sel;
        #2;
        checks++;
        if ((reg_rdata & mask) !== (exp & mask)) begin
            fails++;
            $display("FAIL %s: actual %h expected %h (mask %h)", tag, reg_rdata & mask, exp & mask, mask);
        end
    endtask

    task automatic pulse_read();
        cmd_read = 1'b1; step(); cmd_read = 1'b0;
    endtask

    task automatic select(input logic [4:0] idx);
        reg_write(2'd0, {19'd0, nv_b, 3'd0, idx});
    endtask

    task automatic write_entry(input logic [4:0] idx, input logic v, input logic p,
                               input logic [7:0] tid, input logic ts, input logic [3:0] sz,
                               input logic [19:0] epn, input logic [19:0] rpn,
                               input logic with_flash);
        select(idx);
        reg_write(2'd1, {v, p, 6'd0, tid, 7'd0, ts, 4'd0, sz});
        reg_write(2'd2, {epn, 12'd0});
        reg_write(2'd3, {rpn, 12'd0});
        cmd_write = 1'b1; cmd_flash = with_flash;
        step();
        cmd_write = 1'b0; cmd_flash = 1'b0;
    endtask

    initial begin
        #(8ns * 200000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        reg_check("R1 select after reset", 2'd0, 32'hFFFF_FFFF, 32'h0);
        lookup("R1 no hit after reset", 1'b0, 32'h0001_0000, 8'd0, 1'b0, 1'b0, 1'b0, 5'd0, 32'h0, 1'b0);
        select(5'd3);
        pulse_read();
        reg_check("R1 entry valid clear", 2'd1, 32'h8000_0000, 32'h0);

        // fill entries
        write_entry(5'd0, 1, 0, 8'd0, 0, 4'd0, 20'h00010, 20'h80010, 0);
        write_entry(5'd1, 1, 0, 8'd5, 0, 4'd0, 20'h00020, 20'h90020, 0);
        write_entry(5'd2, 1, 0, 8'd0, 1, 4'd2, 20'h00300, 20'hA0300, 0);
        write_entry(5'd3, 0, 0, 8'd0, 0, 4'd0, 20'h00040, 20'hE0040, 0);
        write_entry(5'd4, 1, 1, 8'd0, 0, 4'd0, 20'h00050, 20'hB0050, 0);

        // R3: global ID and process match
        lookup("R3 global entry any pid", 1'b0, 32'h0001_0ABC, 8'd7, 1'b0, 1'b0, 1'b1, 5'd0, 32'h8001_0ABC, 1'b0);
        lookup("R3 pid match", 1'b1, 32'h0002_0004, 8'd5, 1'b0, 1'b0, 1'b1, 5'd1, 32'h9002_0004, 1'b0);
        lookup("R3 pid mismatch", 1'b1, 32'h0002_0004, 8'd6, 1'b0, 1'b0, 1'b0, 5'd0, 32'h0, 1'b0);
        // R4 and R5: space selection and 64 KB page
        lookup("R5 large page data", 1'b1, 32'h0030_7123, 8'd1, 1'b0, 1'b1, 1'b1, 5'd2, 32'hA030_7123, 1'b0);
        lookup("R4 fetch uses is", 1'b0, 32'h0030_7123, 8'd1, 1'b0, 1'b1, 1'b0, 5'd0, 32'h0, 1'b0);
        lookup("R4 fetch is match", 1'b0, 32'h0030_7123, 8'd1, 1'b1, 1'b0, 1'b1, 5'd2, 32'hA030_7123, 1'b0);
        lookup("R5 page top edge", 1'b1, 32'h0030_F000, 8'd1, 1'b0, 1'b1, 1'b1, 5'd2, 32'hA030_F000, 1'b0);
        lookup("R5 beyond page", 1'b1, 32'h0031_0000, 8'd1, 1'b0, 1'b1, 1'b0, 5'd0, 32'h0, 1'b0);
        // R2 and R8: invalid entry misses, victim loaded
        select(5'd0);
        lookup("R2 invalid entry", 1'b0, 32'h0004_0000, 8'd0, 1'b0, 1'b0, 1'b0, 5'd0, 32'h0, 1'b0);
        reg_check("R8 esel from next-victim", 2'd0, 32'hFFFF_FFFF, 32'h0000_0909);

        // R7: readback
        select(5'd1);
        pulse_read();
        reg_check("R7 context of entry 1", 2'd1, 32'hFFFF_FFFF, 32'h8005_0000);
        reg_check("R7 epn of entry 1", 2'd2, 32'hFFFF_FFFF, 32'h0002_0000);
        reg_check("R7 rpn of entry 1", 2'd3, 32'hFFFF_FFFF, 32'h9002_0000);
        select(5'd2);
        pulse_read();
        reg_check("R7 context of entry 2", 2'd1, 32'hFFFF_FFFF, 32'h8000_0102);

        // R11: reserved bits
        reg_write(2'd0, 32'hFFFF_FFFF);
        reg_check("R11 select reserved", 2'd0, 32'hFFFF_FFFF, 32'h0000_1F1F);
        reg_write(2'd1, 32'hFFFF_FFFF);
        reg_check("R11 context reserved", 2'd1, 32'hFFFF_FFFF, 32'hC0FF_010F);
        reg_write(2'd2, 32'hFFFF_FFFF);
        reg_check("R11 epn reserved", 2'd2, 32'hFFFF_FFFF, 32'hFFFF_F000);

        // R6: multi-hit, lowest index wins
        write_entry(5'd5, 1, 0, 8'd0, 0, 4'd0, 20'h00010, 20'hC0010, 0);
        lookup("R6 multi-hit lowest", 1'b0, 32'h0001_0000, 8'd7, 1'b0, 1'b0, 1'b1, 5'd0, 32'h8001_0000, 1'b1);

        // R9: invalidate by address
        inv_pn = 20'h00010; cmd_inval = 1'b1; step(); cmd_inval = 1'b0;
        lookup("R9 unprotected removed", 1'b0, 32'h0001_0800, 8'd7, 1'b0, 1'b0, 1'b0, 5'd0, 32'h0, 1'b0);
        inv_pn = 20'h00050; cmd_inval = 1'b1; step(); cmd_inval = 1'b0;
        lookup("R9 protected kept", 1'b1, 32'h0005_0FFF, 8'd2, 1'b0, 1'b0, 1'b1, 5'd4, 32'hB005_0FFF, 1'b0);

        // R10: flash with a simultaneous write of entry 6
        write_entry(5'd6, 1, 0, 8'd0, 0, 4'd0, 20'h00060, 20'hD0060, 1);
        lookup("R10 flash clears entry 1", 1'b1, 32'h0002_0004, 8'd5, 1'b0, 1'b0, 1'b0, 5'd0, 32'h0, 1'b0);
        lookup("R10 flash clears entry 2", 1'b1, 32'h0030_7123, 8'd1, 1'b0, 1'b1, 1'b0, 5'd0, 32'h0, 1'b0);
        lookup("R10 protected survives", 1'b1, 32'h0005_0010, 8'd2, 1'b0, 1'b0, 1'b1, 5'd4, 32'hB005_0010, 1'b0);
        lookup("R10 same-cycle write wins", 1'b0, 32'h0006_0010, 8'd3, 1'b0, 1'b0, 1'b1, 5'd6, 32'hD006_0010, 1'b0);
        select(5'd1);
        pulse_read();
        reg_check("R10 entry 1 read invalid", 2'd1, 32'hFFFF_FFFF, 32'h0005_0000);

        step();
        if (sb_q.size() != 0) begin
            checks++; fails++;
            $display("FAIL scoreboard: actual %0d items left expected 0", sb_q.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule